// File: doc/BRIEF.md
# Polyphase Scaler Coefficient Loader

This block is the register-side store for the filter coefficients of a polyphase scaler. It holds two independent coefficient sets. Each set is a table of 17 phases by 7 taps, with 119 sixteen-bit entries in all. Software fills a set in two steps. It first writes that set's index register, which gives a start position and may turn on automatic advance. It then sends a stream of 32-bit data words to that set's data register. Each data word carries two entries.

A flat entry number n belongs to phase n / 7 and tap n % 7. A full set therefore takes 60 data words. The upper half of the sixtieth word falls past the end of the table and is discarded. The filtering datapath reads a coefficient by set, phase and tap. It places a request on `rd_req`, and the entry appears one cycle later with `rd_valid`.

The read port has no back-pressure. A request is accepted in every cycle it is raised, so there is no ready signal, and each request produces exactly one response one cycle later. The write port is a plain strobe that completes in one cycle.

Top module: `coef_bank_loader`

## Requirements
- R1: After reset, `rd_valid` is 0, both set indices are 0 and automatic advance is off for both sets. A data write issued before any index write therefore lands on entries 0 and 1, and the next one overwrites them.
- R2: The write address decodes as follows. `wr_addr[1]` selects the set (0 or 1). `wr_addr[0]` = 0 selects that set's index register, and `wr_addr[0]` = 1 selects its data register.
- R3: An index-register write loads the start index from `wr_data[6:0]` and the advance enable from `wr_data[10]`. A start value above 119 is loaded as 119.
- R4: A data write stores `wr_data[15:0]` at the current index and `wr_data[31:16]` at the current index + 1.
- R5: When advance is enabled, the index grows by 2 after each data write, so 60 consecutive words fill entries 0 to 118 in order.
- R6: When advance is disabled, a data write leaves the index unchanged, so repeated words overwrite the same two entries.
- R7: A half-word whose target index is 119 or above is dropped and changes no entry. The index saturates at 119 and never wraps.
- R8: The two sets have separate indices, enables and tables. A write to one set changes nothing in the other.
- R9: `rd_valid` is high exactly one cycle after `rd_req` was high. `rd_coef` then holds the entry at phase × 7 + tap of set `rd_set`.
- R10: A read request with a phase of 17 or above, or a tap of 7 or above, returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: bit 1 = set, bit 0 = index (0) or data (1) |
| wr_data | input | 32 | Register write data |
| rd_req | input | 1 | Coefficient read request, accepted every cycle |
| rd_set | input | 1 | Coefficient set to read |
| rd_phase | input | 5 | Phase to read, 0 to 16 |
| rd_tap | input | 3 | Tap to read, 0 to 6 |
| rd_valid | output | 1 | Read response valid, one cycle after the request |
| rd_coef | output | 16 | Coefficient read data |

## Verification
The bench loads a full set and reads back all 119 entries by phase and tap. A design that packed the halves in the wrong order, or advanced the index by 1, would show shifted or swapped entries. It then goes after the tail of the table. Starting at 116, three words must fill 116 to 118 and leave entry 0 intact. A design that wrapped the index, or that failed to drop the upper half of the last word, would corrupt the start of the table. Start values above 119, the hold behaviour with advance off, and out-of-range reads are each checked. So is set isolation, since a shared index or a misdecoded address bit would leak one set's words into the other.

// File: rtl/coef_ld_pkg.sv
package coef_ld_pkg;
  localparam int NUM_SETS = 2;
  localparam int HALF_W   = 16;

  typedef enum logic {
    REG_INDEX = 1'b0,
    REG_DATA  = 1'b1
  } reg_kind_e;
endpackage

// File: rtl/coef_idx_ctrl.sv
module coef_idx_ctrl #(
  parameter int ENTRIES  = 119,
  parameter int IDX_W    = 7,
  parameter int AUTO_BIT = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic             data_en,
  input  logic [31:0]      wr_data,
  output logic [IDX_W-1:0] lo_idx,
  output logic [IDX_W-1:0] hi_idx,
  output logic             lo_we,
  output logic             hi_we
);
  localparam logic [IDX_W-1:0] LAST     = IDX_W'(ENTRIES);
  localparam logic [IDX_W-1:0] STEP_LIM = IDX_W'(ENTRIES - 2);

  logic [IDX_W-1:0] idx_q;
  logic             auto_q;
  logic [IDX_W-1:0] start_val;
  logic [31:0]      unused_wr_bits;

  assign unused_wr_bits = wr_data;
  assign start_val = (wr_data[IDX_W-1:0] > LAST) ? LAST : wr_data[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      auto_q <= 1'b0;
    end else if (load_en) begin
      idx_q  <= start_val;
      auto_q <= wr_data[AUTO_BIT];
    end else if (data_en && auto_q) begin
      idx_q  <= (idx_q >= STEP_LIM) ? LAST : idx_q + IDX_W'(2);
    end
  end

  assign lo_idx = idx_q;
  assign hi_idx = idx_q + IDX_W'(1);
  assign lo_we  = data_en && (idx_q < LAST);
  assign hi_we  = data_en && (hi_idx < LAST);

  // R7: the index never passes the end of the table
  a_r7_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LAST);

  // R5: advance by two below the tail
  a_r5_step_two: assert property (@(posedge clk) disable iff (!rst_n)
    (data_en && !load_en && auto_q && idx_q < STEP_LIM) |=> idx_q == $past(idx_q) + IDX_W'(2));

  // R7: advance saturates at the tail
  a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (data_en && !load_en && auto_q && idx_q >= STEP_LIM) |=> idx_q == LAST);

  // R6: no advance when disabled
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (data_en && !load_en && !auto_q) |=> $stable(idx_q));
endmodule

// File: rtl/coef_bank_ram.sv
module coef_bank_ram #(
  parameter int ENTRIES = 119,
  parameter int COEF_W  = 16,
  parameter int IDX_W   = 7
) (
  input  logic              clk,
  input  logic              we_a,
  input  logic [IDX_W-1:0]  addr_a,
  input  logic [COEF_W-1:0] din_a,
  input  logic              we_b,
  input  logic [IDX_W-1:0]  addr_b,
  input  logic [COEF_W-1:0] din_b,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic [COEF_W-1:0] rd_data
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES);

  logic [COEF_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we_a) mem[addr_a] <= din_a;
    if (we_b) mem[addr_b] <= din_b;
  end

  assign rd_data = (rd_addr < LAST) ? mem[rd_addr] : '0;

  // R4: the two halves of one word never target the same entry
  a_r4_distinct_ports: assert property (@(posedge clk)
    (we_a && we_b) |-> addr_a != addr_b);
endmodule

// File: rtl/coef_read_port.sv
module coef_read_port #(
  parameter int NUM_PHASES = 17,
  parameter int NUM_TAPS   = 7,
  parameter int NUM_SETS   = 2,
  parameter int COEF_W     = 16,
  parameter int IDX_W      = 7,
  parameter int PH_W       = 5,
  parameter int TP_W       = 3,
  parameter int SET_W      = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rd_req,
  input  logic [SET_W-1:0]           rd_set,
  input  logic [PH_W-1:0]            rd_phase,
  input  logic [TP_W-1:0]            rd_tap,
  input  logic [NUM_SETS*COEF_W-1:0] bank_data,
  output logic [IDX_W-1:0]           flat_addr,
  output logic                       rd_valid,
  output logic [COEF_W-1:0]          rd_coef
);
  logic [31:0]       flat32;
  logic              in_range;
  logic [COEF_W-1:0] picked;
  logic [31:0]       unused_flat;

  assign flat32      = 32'(rd_phase) * 32'(NUM_TAPS) + 32'(rd_tap);
  assign unused_flat = flat32;
  assign flat_addr   = flat32[IDX_W-1:0];
  assign in_range    = (32'(rd_phase) < 32'(NUM_PHASES)) && (32'(rd_tap) < 32'(NUM_TAPS));

  always_comb begin
    picked = '0;
    for (int s = 0; s < NUM_SETS; s++) begin
      if (32'(rd_set) == s) picked = bank_data[s*COEF_W +: COEF_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_coef  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_coef <= in_range ? picked : '0;
    end
  end

  // R9: one response per request, one cycle later
  a_r9_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);

  // R10: out-of-range coordinates read as zero
  a_r10_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !in_range) |=> rd_coef == '0);
endmodule

// File: rtl/coef_bank_loader.sv
module coef_bank_loader #(
  parameter int NUM_PHASES = 17,
  parameter int NUM_TAPS   = 7,
  parameter int AUTO_BIT   = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic        rd_req,
  input  logic        rd_set,
  input  logic [4:0]  rd_phase,
  input  logic [2:0]  rd_tap,
  output logic        rd_valid,
  output logic [15:0] rd_coef
);
  import coef_ld_pkg::*;

  localparam int ENTRIES = NUM_PHASES * NUM_TAPS;
  localparam int IDX_W   = $clog2(ENTRIES + 1);
  localparam int COEF_W  = HALF_W;

  reg_kind_e                  kind;
  logic [IDX_W-1:0]           flat_addr;
  logic [NUM_SETS*COEF_W-1:0] bank_data;

  assign kind = reg_kind_e'(wr_addr[0]);

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    logic             sel;
    logic             load_en, data_en;
    logic [IDX_W-1:0] lo_idx, hi_idx;
    logic             lo_we, hi_we;

    assign sel     = wr_en && (wr_addr[1] == s[0]);
    assign load_en = sel && (kind == REG_INDEX);
    assign data_en = sel && (kind == REG_DATA);

    coef_idx_ctrl #(
      .ENTRIES(ENTRIES), .IDX_W(IDX_W), .AUTO_BIT(AUTO_BIT)
    ) u_idx (
      .clk(clk), .rst_n(rst_n), .load_en(load_en), .data_en(data_en),
      .wr_data(wr_data), .lo_idx(lo_idx), .hi_idx(hi_idx),
      .lo_we(lo_we), .hi_we(hi_we)
    );

    coef_bank_ram #(
      .ENTRIES(ENTRIES), .COEF_W(COEF_W), .IDX_W(IDX_W)
    ) u_ram (
      .clk(clk),
      .we_a(lo_we), .addr_a(lo_idx), .din_a(wr_data[COEF_W-1:0]),
      .we_b(hi_we), .addr_b(hi_idx), .din_b(wr_data[2*COEF_W-1:COEF_W]),
      .rd_addr(flat_addr), .rd_data(bank_data[s*COEF_W +: COEF_W])
    );

    // R8: a set's table is written only through its own register
    a_r8_isolation: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_we || hi_we) |-> (wr_en && wr_addr[1] == s[0] && wr_addr[0]));
  end

  coef_read_port #(
    .NUM_PHASES(NUM_PHASES), .NUM_TAPS(NUM_TAPS), .NUM_SETS(NUM_SETS),
    .COEF_W(COEF_W), .IDX_W(IDX_W), .PH_W(5), .TP_W(3), .SET_W(1)
  ) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_set(rd_set),
    .rd_phase(rd_phase), .rd_tap(rd_tap), .bank_data(bank_data),
    .flat_addr(flat_addr), .rd_valid(rd_valid), .rd_coef(rd_coef)
  );
endmodule

// File: tb/coef_bank_loader_bench.sv
module coef_bank_loader_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_req = 1'b0;
  logic        rd_set = 1'b0;
  logic [4:0]  rd_phase = '0;
  logic [2:0]  rd_tap = '0;
  logic        rd_valid;
  logic [15:0] rd_coef;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  coef_bank_loader u_coef_bank_loader (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_req(rd_req), .rd_set(rd_set),
    .rd_phase(rd_phase), .rd_tap(rd_tap), .rd_valid(rd_valid),
    .rd_coef(rd_coef)
  );

  function automatic logic [15:0] pat(input int s, input int n);
    return {(s == 1) ? 8'hC3 : 8'h5A, 8'(n)};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input int s, input bit is_data, input logic [31:0] d);
    wr_en = 1'b1;
    wr_addr = {s[0], is_data};
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input int s, input int ph, input int tp,
                        input logic [15:0] exp);
    rd_req = 1'b1;
    rd_set = s[0];
    rd_phase = 5'(ph);
    rd_tap = 3'(tp);
    @(negedge clk);
    rd_req = 1'b0;
    checks++;
    if (rd_valid !== 1'b1 || rd_coef !== exp) begin
      errors++;
      $display("FAIL %s set=%0d ph=%0d tap=%0d actual=%h/%b expected=%h/1",
               tag, s, ph, tp, rd_coef, rd_valid, exp);
    end
  endtask

  task automatic rd_entry(input string tag, input int s, input int n, input logic [15:0] exp);
    rd_chk(tag, s, n / 7, n % 7, exp);
  endtask

  task automatic load_set(input int s);
    reg_wr(s, 1'b0, 32'h0000_0400);
    for (int k = 0; k < 60; k++) reg_wr(s, 1'b1, {pat(s, 2*k+1), pat(s, 2*k)});
  endtask

  task automatic t_reset;
    check("R1 rd_valid after reset", {31'd0, rd_valid}, 32'd0);
    reg_wr(0, 1'b1, 32'hBBBB_AAAA);
    reg_wr(0, 1'b1, 32'hDDDD_CCCC);
    rd_entry("R1 entry0 overwritten", 0, 0, 16'hCCCC);
    rd_entry("R1 entry1 overwritten", 0, 1, 16'hDDDD);
  endtask

  task automatic t_full_load;
    load_set(0);
    for (int n = 0; n < 119; n++) rd_entry("R4 R5 R9 full load", 0, n, pat(0, n));
  endtask

  task automatic t_set_indep;
    load_set(1);
    rd_entry("R8 set1 entry0", 1, 0, pat(1, 0));
    rd_entry("R8 set1 entry118", 1, 118, pat(1, 118));
    rd_entry("R2 R8 set0 entry0 kept", 0, 0, pat(0, 0));
    rd_entry("R8 set0 entry57 kept", 0, 57, pat(0, 57));
    rd_entry("R8 set0 entry118 kept", 0, 118, pat(0, 118));
  endtask

  task automatic t_no_auto;
    reg_wr(0, 1'b0, 32'd20);
    reg_wr(0, 1'b1, 32'h1111_2222);
    reg_wr(0, 1'b1, 32'h3333_4444);
    rd_entry("R3 R6 entry20", 0, 20, 16'h4444);
    rd_entry("R6 entry21", 0, 21, 16'h3333);
    rd_entry("R6 entry22 untouched", 0, 22, pat(0, 22));
    rd_entry("R8 set1 entry20 untouched", 1, 20, pat(1, 20));
  endtask

  task automatic t_tail;
    reg_wr(1, 1'b0, 32'h0000_0474);
    reg_wr(1, 1'b1, 32'hAAAA_0001);
    reg_wr(1, 1'b1, 32'hAAAA_0002);
    reg_wr(1, 1'b1, 32'hAAAA_0003);
    rd_entry("R7 entry116", 1, 116, 16'h0001);
    rd_entry("R7 entry117", 1, 117, 16'hAAAA);
    rd_entry("R7 entry118", 1, 118, 16'h0002);
    rd_entry("R7 no wrap entry0", 1, 0, pat(1, 0));
    rd_entry("R7 no wrap entry1", 1, 1, pat(1, 1));
  endtask

  task automatic t_clamp;
    reg_wr(0, 1'b0, 32'h0000_047F);
    reg_wr(0, 1'b1, 32'h5555_5555);
    reg_wr(0, 1'b1, 32'h6666_6666);
    rd_entry("R3 clamp entry118", 0, 118, pat(0, 118));
    rd_entry("R3 clamp entry0", 0, 0, pat(0, 0));
    rd_entry("R3 clamp entry1", 0, 1, pat(0, 1));
  endtask

  task automatic t_bad_read;
    rd_chk("R10 phase17", 0, 17, 0, 16'h0000);
    rd_chk("R10 tap7", 1, 0, 7, 16'h0000);
    rd_chk("R10 phase31 tap7", 0, 31, 7, 16'h0000);
    @(negedge clk);
    check("R9 no request no valid", {31'd0, rd_valid}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_load();
    t_set_indep();
    t_no_auto();
    t_tail();
    t_clamp();
    t_bad_read();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule